// File: doc/BRIEF.md
# Precharged Internal Bus Register Port

This block is a cycle-level model of how a processor writes into the colour register file of a video controller. Pin data does not go straight into a register. It first passes through an internal data bus. That bus is precharged to all ones in fixed sub-slots and is driven from the data pins only in certain clock phases. A fast clock steps a three-bit slot counter. From that counter the block derives the two-phase enables of the 1 MHz, 2 MHz and 4 MHz clocks, and those enables decide, slot by slot, who owns the internal bus.

The write strobe is level-sensitive. While chip-select and read/write are both low, the addressed register copies the internal bus in every slot. Whatever the bus carries in the last slot of the strobe stays in the register. If the strobe is released right after a precharge slot, the register keeps all ones instead of the pin data. The block exists to reproduce that glitch. Outputs are the flattened register contents, a debug view of the internal bus and a flag that goes high when the pins and the precharge both drive the bus.

Top module: `precharge_reg_port`

## Requirements
- R1: After reset, every colour register reads 0, the internal bus view reads all ones (0x7F) and the slot counter is 0. The counter then advances by one slot per clock and wraps from 7 to 0.
- R2: The write strobe is active only while cs_n and rw_n are both low. With cs_n low and rw_n high, or with cs_n high and rw_n low, no register changes.
- R3: While the strobe is active, the register selected by reg_sel takes the value the internal bus carries in that slot, on every slot of the strobe. The last slot decides the final value, and the other registers are left unchanged.
- R4: The bus is precharged to all ones in slots 1 and 5. These are the slots where the first 2 MHz phase and the second 4 MHz phase overlap.
- R5: The pins drive the bus in slots 2 and 3 in every cycle, and in slots 6 and 7 only while cpu_addr_en is high or the strobe is active. They never drive it in slots 0, 1, 4 or 5.
- R6: In a slot where neither the pins nor the precharge drive the bus, the bus keeps its previous value. A strobe held only in such a slot writes that held value, not the current pin data.
- R7: A strobe held from slot 4 through slot 7 leaves the pin data in the register.
- R8: A strobe released right after a precharge slot leaves 0x7F in the register, even if pin data reached the bus earlier in the strobe.
- R9: clash_dbg, which is high when pin drive and precharge fall in the same slot, never goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip-select |
| rw_n | input | 1 | High for read, low for write |
| cpu_addr_en | input | 1 | Address-enable qualifier from the processor side |
| reg_sel | input | 3 | Colour register index |
| pin_data | input | 7 | Data pins |
| colour_regs | output | 56 | Register contents; register i at bits [7*i+6:7*i] |
| ibus_dbg | output | 7 | Internal bus value as registered at the end of the previous slot |
| clash_dbg | output | 1 | Pins and precharge driving the bus in the same slot |

## Verification
The hardest case to reach is a register that ends with all ones even though valid pin data was on the bus earlier in the same strobe. To get there, the bench has to open the strobe in slot 0, let slots 2 and 3 carry the pin data, and close the strobe exactly after precharge slot 5. The bench keeps its own slot count from reset, so each case can line up chip-select and read/write with a chosen slot. One more case opens the strobe only in slot 4 and changes the pins during it. That case separates a held bus value from the live pin value.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    localparam int SLOT_W = 3;

    // two-phase enables of the three derived clock rates
    typedef struct packed {
        logic ph1;   // 1 MHz first half
        logic ph2;   // 1 MHz second half
        logic h1;    // 2 MHz first half
        logic h2;    // 2 MHz second half
        logic q1;    // 4 MHz first half
        logic q2;    // 4 MHz second half
    } phase_t;

endpackage

// File: rtl/pbr_phase_seq.sv
module pbr_phase_seq
    import pbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output phase_t            ph_o
);

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slot = st_q.slot + 1'b1;
        ph_o.ph1  = ~st_q.slot[2];
        ph_o.ph2  =  st_q.slot[2];
        ph_o.h1   = ~st_q.slot[1];
        ph_o.h2   =  st_q.slot[1];
        ph_o.q1   = ~st_q.slot[0];
        ph_o.q2   =  st_q.slot[0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_o = st_q.slot;

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> slot_o == $past(slot_o) + 1'b1); // R1

endmodule

// File: rtl/pbr_int_bus.sv
module pbr_int_bus
    import pbr_pkg::*;
#(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        ph,
    input  logic          wr,
    input  logic          addr_en,
    input  logic [DW-1:0] pins,
    output logic [DW-1:0] bus_now,
    output logic [DW-1:0] bus_q_o,
    output logic          clash
);

    typedef struct packed {
        logic [DW-1:0] bus;
    } bus_state_t;

    bus_state_t st_d, st_q;
    logic       pin_drive;
    logic       precharge;

    always_comb begin
        pin_drive = (ph.ph1 | (ph.ph2 & addr_en) | wr) & ~ph.h1;
        precharge = ph.h1 & ph.q2;
        clash     = pin_drive & precharge;
        if (precharge)      bus_now = '1;
        else if (pin_drive) bus_now = pins;
        else                bus_now = st_q.bus;
        st_d      = st_q;
        st_d.bus  = bus_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.bus <= '1;
        else        st_q     <= st_d;
    end

    assign bus_q_o = st_q.bus;

    AST_PRECHARGE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        precharge |=> bus_q_o == {DW{1'b1}}); // R4
    AST_PIN_TO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_drive && !precharge) |=> bus_q_o == $past(pins)); // R5
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_drive && !precharge) |=> $stable(bus_q_o)); // R6
    AST_FIRST_HALF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ph.h1 && !ph.q2) |=> $stable(bus_q_o)); // R5

endmodule

// File: rtl/pbr_colour_regs.sv
module pbr_colour_regs
    import pbr_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 7,
    localparam int AW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [AW-1:0]      sel,
    input  logic [DW-1:0]      bus_now,
    output logic [NREG*DW-1:0] regs_o
);

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr && sel == AW'(i)) st_d.regs[i] = bus_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[g*DW +: DW] = st_q.regs[g];
    end

    AST_NO_STROBE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(regs_o)); // R2
    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> st_q.regs[$past(sel)] == $past(bus_now)); // R3

endmodule

// File: rtl/precharge_reg_port.sv
module precharge_reg_port
    import pbr_pkg::*;
#(
    parameter int NREG = 8,
    parameter int DW   = 7,
    localparam int AW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs_n,
    input  logic               rw_n,
    input  logic               cpu_addr_en,
    input  logic [AW-1:0]      reg_sel,
    input  logic [DW-1:0]      pin_data,
    output logic [NREG*DW-1:0] colour_regs,
    output logic [DW-1:0]      ibus_dbg,
    output logic               clash_dbg
);

    logic [SLOT_W-1:0] slot;
    phase_t            ph;
    logic              wr_strobe;
    logic [DW-1:0]     bus_now;

    always_comb begin
        wr_strobe = ~cs_n & ~rw_n;
    end

    pbr_phase_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot),
        .ph_o   (ph)
    );

    pbr_int_bus #(.DW(DW)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .ph      (ph),
        .wr      (wr_strobe),
        .addr_en (cpu_addr_en),
        .pins    (pin_data),
        .bus_now (bus_now),
        .bus_q_o (ibus_dbg),
        .clash   (clash_dbg)
    );

    pbr_colour_regs #(.NREG(NREG), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_strobe),
        .sel     (reg_sel),
        .bus_now (bus_now),
        .regs_o  (colour_regs)
    );

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !clash_dbg); // R9
    AST_PRECHARGE_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == 3'd1 || slot == 3'd5) |=> ibus_dbg == {DW{1'b1}}); // R4

endmodule

// File: tb/precharge_reg_port_tb_top.sv
module precharge_reg_port_tb_top;

    localparam int NREG = 8;
    localparam int DW   = 7;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cs_n = 1'b1;
    logic               rw_n = 1'b1;
    logic               cpu_addr_en = 1'b0;
    logic [2:0]         reg_sel = '0;
    logic [DW-1:0]      pin_data = '0;
    logic [NREG*DW-1:0] colour_regs;
    logic [DW-1:0]      ibus_dbg;
    logic               clash_dbg;

    int checks = 0;
    int fails  = 0;
    int clash_seen = 0;
    int pe = 0;
    bit done = 0;

    typedef struct {
        bit         is_bus;
        int         idx;
        logic [6:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #5 clk = ~clk;

    precharge_reg_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .rw_n        (rw_n),
        .cpu_addr_en (cpu_addr_en),
        .reg_sel     (reg_sel),
        .pin_data    (pin_data),
        .colour_regs (colour_regs),
        .ibus_dbg    (ibus_dbg),
        .clash_dbg   (clash_dbg)
    );

    // bench's own slot count, advanced on the same edges as the design
    always @(posedge clk) begin
        if (!rst_n) pe <= 0;
        else        pe <= pe + 1;
    end

    always @(negedge clk) begin
        if (rst_n && clash_dbg) clash_seen++;
    end

    task automatic goto_slot(input int s);
        do @(negedge clk); while ((pe % 8) != s);
    endtask

    task automatic exp_reg(input int idx, input logic [6:0] v, input string req);
        item_t it;
        it.is_bus = 0; it.idx = idx; it.exp = v; it.req = req;
        sb_q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    task automatic exp_bus(input logic [6:0] v, input string req);
        item_t it;
        it.is_bus = 1; it.idx = 0; it.exp = v; it.req = req;
        sb_q.push_back(it);
        -> chk_ev;
        #2;
    endtask

    // monitor: pops expectations and compares to the ports
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [6:0] act;
                it = sb_q.pop_front();
                act = it.is_bus ? ibus_dbg : colour_regs[it.idx*DW +: DW];
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: %s actual=%h expected=%h", it.req,
                             it.is_bus ? "bus" : $sformatf("reg%0d", it.idx), act, it.exp);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int i = 0; i < NREG; i++) exp_reg(i, 7'h00, "R1");
        exp_bus(7'h7F, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R7: strobe from slot 4 through 7 ends with pin data
        goto_slot(2); pin_data = 7'h15; reg_sel = 3'd3;
        goto_slot(4); cs_n = 0; rw_n = 0;
        goto_slot(0); cs_n = 1; rw_n = 1;
        exp_reg(3, 7'h15, "R7");
        exp_bus(7'h15, "R7");

        // R8: strobe over slots 0..5, released after precharge slot 5
        goto_slot(0); reg_sel = 3'd5; pin_data = 7'h2A; cs_n = 0; rw_n = 0;
        goto_slot(6); cs_n = 1; rw_n = 1;
        exp_reg(5, 7'h7F, "R8");
        exp_bus(7'h7F, "R4");

        // R6: strobe only in slot 4 takes the held bus, not the live pins
        goto_slot(2); pin_data = 7'h0C; reg_sel = 3'd1;
        goto_slot(4); cs_n = 0; rw_n = 0; pin_data = 7'h33;
        goto_slot(5); cs_n = 1; rw_n = 1;
        exp_reg(1, 7'h0C, "R6");
        exp_bus(7'h0C, "R5");

        // R4/R3: strobe only in precharge slot 1
        goto_slot(1); reg_sel = 3'd2; pin_data = 7'h05; cs_n = 0; rw_n = 0;
        goto_slot(2); cs_n = 1; rw_n = 1;
        exp_reg(2, 7'h7F, "R3");

        // R2: select with read level for a whole cycle
        goto_slot(0); reg_sel = 3'd3; pin_data = 7'h01; cs_n = 0; rw_n = 1;
        goto_slot(0); cs_n = 1;
        exp_reg(3, 7'h15, "R2");
        exp_bus(7'h7F, "R5"); // slots 6,7 undriven without addr enable

        // R2: write level without select for a whole cycle
        goto_slot(0); pin_data = 7'h02; rw_n = 0;
        goto_slot(0); rw_n = 1;
        exp_reg(3, 7'h15, "R2");

        // R5: addr enable lets pins drive in slot 6
        goto_slot(6); cpu_addr_en = 1; pin_data = 7'h41;
        goto_slot(7); cpu_addr_en = 0;
        exp_bus(7'h41, "R5");

        // R5: slot 3 drives from pins regardless
        goto_slot(3); pin_data = 7'h22;
        goto_slot(4);
        exp_bus(7'h22, "R5");

        // R3: untouched registers unchanged
        exp_reg(0, 7'h00, "R3");
        exp_reg(4, 7'h00, "R3");
        exp_reg(7, 7'h00, "R3");

        // R9: no contention seen over the whole run
        checks++;
        if (clash_seen != 0) begin
            fails++;
            $display("FAIL R9: clash count actual=%0d expected=0", clash_seen);
        end

        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule